// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides which interrupt a 16550-style serial port reports, and whether its single request line is raised. Its inputs are the interrupt enable bits, the receive-side status, the transmitter-empty indications and the modem input lines. It keeps the few pieces of state that software clears by reading: the sticky overrun and break flags, the four modem delta flags and the transmitter-empty pending flag. The FIFOs, the shifters and the baud logic are sibling blocks that feed it levels and one-cycle event pulses.

Five sources are checked in a fixed priority order. The winner's code is placed in the low nibble of the identification byte. The upper two bits show whether the FIFOs are on. The identification byte and the request line are registered, so they change on the clock edge after the inputs that cause the change are sampled. The read strobes act on the byte that software sees at that moment.

Top module: `uart_irq_ident`

## Requirements
- R1: While `rst` is high at a clock edge, `iir` becomes 0x01 and `irq` goes low after that edge. The sticky overrun and break flags, the modem delta flags and the transmitter pending flag are all cleared.
- R2: The low nibble of `iir` names the highest-priority active source. In order from highest to lowest: line status 0x6, character timeout 0xC, received data 0x4, transmitter empty 0x2, modem status 0x0. With no source active it is 0x1. Both `iir` and `irq` take the value computed from the inputs and state sampled at the previous clock edge.
- R3: The line status source is active when `ier[2]` is set and any of the sticky overrun flag, the sticky break flag, `pe_flag` or `fe_flag` is set.
- R4: The character timeout source is active only when `tout_pend` and `ier[0]` are both set. No other enable bit affects it.
- R5: The received data source needs `ier[0]` and `data_ready`. While `fifo_en` is high it also needs `rx_count` to be at least the trigger level. For `trig_sel` values 0, 1, 2 and 3 the trigger level is 1, DEPTH/4, DEPTH/2 and DEPTH-2. While `fifo_en` is low, the received data source ignores `rx_count`.
- R6: `iir[7:6]` reads 11 when `fifo_en` was high at the sampling edge, and 00 otherwise. `iir[5:4]` are always 0.
- R7: `irq` is high exactly when the low nibble of `iir` differs from 0x1.
- R8: A pulse on `iir_rd` while `iir[3:0]` is 0x2 clears the transmitter pending flag. A pulse on `iir_rd` while `iir[3:0]` shows any other code leaves the flag unchanged.
- R9: `lsr_sticky` is {break, overrun}. An `oe_evt` or `brk_evt` pulse sets its flag. `lsr_rd` clears both flags, but a set pulse in the same cycle takes precedence over the clear.
- R10: `msr_delta` bit 0 is set by a change of `modem_lines[0]` (CTS), bit 1 by a change of line 1 (DSR), bit 2 by a 1-to-0 transition of line 2 (RI) and bit 3 by a change of line 3 (DCD). `msr_rd` clears all four flags, but a new change in the same cycle takes precedence. The modem status source is active when `ier[3]` is set and any delta flag is set.
- R11: A `tx_empty_evt` pulse sets the transmitter pending flag. A 0-to-1 change of `ier[1]` while `thre` is high also sets it. A `thr_wr` pulse clears it, and a set in the same cycle takes precedence over the clear. The transmitter source is active when `ier[1]` is set and the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier | input | 4 | Enables: 0 received data and timeout, 1 transmitter, 2 line status, 3 modem |
| fifo_en | input | 1 | FIFOs enabled |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CNT_W | Receive FIFO fill count |
| data_ready | input | 1 | Receive data present |
| tout_pend | input | 1 | Character timeout pending |
| pe_flag | input | 1 | Parity error on head character |
| fe_flag | input | 1 | Framing error on head character |
| oe_evt | input | 1 | Overrun event pulse |
| brk_evt | input | 1 | Break received pulse |
| thre | input | 1 | Transmit holding empty level |
| tx_empty_evt | input | 1 | Transmitter became empty pulse |
| thr_wr | input | 1 | Write to transmit holding register |
| modem_lines | input | 4 | Synchronized {DCD, RI, DSR, CTS} |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |
| lsr_sticky | output | 2 | {break, overrun} sticky flags |
| msr_delta | output | 4 | Modem delta flags |

## Verification
The bench builds the block with the default depth of 16, which gives trigger levels 1, 4, 8 and 14. It drives `rx_count` over the full range 0 to 16, so each level is tried one below and exactly at its threshold. The depth is small enough that random counts land on every level often, while the priority chain and the clear-on-read set/clear collisions are hit many times in the random phase.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 5;

  localparam logic [3:0] CODE_NONE = 4'h1;
  localparam logic [3:0] CODE_LINE = 4'h6;
  localparam logic [3:0] CODE_TOUT = 4'hC;
  localparam logic [3:0] CODE_RXD  = 4'h4;
  localparam logic [3:0] CODE_THRE = 4'h2;
  localparam logic [3:0] CODE_MDM  = 4'h0;

  // Index order is priority order, index 0 highest.
  typedef enum logic [2:0] {
    SRC_LINE = 3'd0,
    SRC_TOUT = 3'd1,
    SRC_RXD  = 3'd2,
    SRC_THRE = 3'd3,
    SRC_MDM  = 3'd4
  } irq_src_e;

  function automatic logic [3:0] src_code(input int idx);
    case (idx)
      0:       return CODE_LINE;
      1:       return CODE_TOUT;
      2:       return CODE_RXD;
      3:       return CODE_THRE;
      default: return CODE_MDM;
    endcase
  endfunction

  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_line_flags.sv
module uart_irq_line_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_evt,
  input  logic             clr_rd,
  output logic [NFLAG-1:0] flags
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags[g] <= 1'b0;
      else     flags[g] <= set_evt[g] | (flags[g] & ~clr_rd);
    end
  end
endmodule

// File: rtl/uart_irq_modem_delta.sv
module uart_irq_modem_delta (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] lines,
  input  logic       clr_rd,
  output logic [3:0] delta
);
  logic [3:0] prev_q;
  logic [3:0] change;

  always_comb begin
    change[0] = lines[0] ^ prev_q[0];
    change[1] = lines[1] ^ prev_q[1];
    change[2] = prev_q[2] & ~lines[2];
    change[3] = lines[3] ^ prev_q[3];
  end

  always_ff @(posedge clk) begin
    prev_q <= lines;
    if (rst) delta <= 4'h0;
    else     delta <= change | (delta & {4{~clr_rd}});
  end
endmodule

// File: rtl/uart_irq_thr_pend.sv
module uart_irq_thr_pend (
  input  logic clk,
  input  logic rst,
  input  logic thr_en,
  input  logic thre,
  input  logic tx_empty_evt,
  input  logic thr_wr,
  input  logic iir_rd,
  input  logic shown_thre,
  output logic pend
);
  logic en_prev_q;
  logic set_now;
  logic clr_now;

  assign set_now = tx_empty_evt | (thr_en & ~en_prev_q & thre);
  assign clr_now = thr_wr | (iir_rd & shown_thre);

  always_ff @(posedge clk) begin
    en_prev_q <= thr_en;
    if (rst) pend <= 1'b0;
    else     pend <= set_now | (pend & ~clr_now);
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic            fifo_en,
  output logic [7:0]      iir,
  output logic            irq
);
  logic [3:0] code;

  always_comb begin
    code = CODE_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) code = src_code(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iir <= {4'h0, CODE_NONE};
      irq <= 1'b0;
    end else begin
      iir <= {{2{fifo_en}}, 2'b00, code};
      irq <= (code != CODE_NONE);
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ier,
  input  logic             fifo_en,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             data_ready,
  input  logic             tout_pend,
  input  logic             pe_flag,
  input  logic             fe_flag,
  input  logic             oe_evt,
  input  logic             brk_evt,
  input  logic             thre,
  input  logic             tx_empty_evt,
  input  logic             thr_wr,
  input  logic [3:0]       modem_lines,
  input  logic             iir_rd,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  output logic [7:0]       iir,
  output logic             irq,
  output logic [1:0]       lsr_sticky,
  output logic [3:0]       msr_delta
);
  logic [CNT_W-1:0] level;
  logic             thr_pend;
  logic [NSRC-1:0]  req;

  assign level = CNT_W'(trig_level(trig_sel, DEPTH));

  uart_irq_line_flags #(.NFLAG(2)) u_line (
    .clk(clk), .rst(rst), .set_evt({brk_evt, oe_evt}),
    .clr_rd(lsr_rd), .flags(lsr_sticky)
  );

  uart_irq_modem_delta u_mdm (
    .clk(clk), .rst(rst), .lines(modem_lines),
    .clr_rd(msr_rd), .delta(msr_delta)
  );

  uart_irq_thr_pend u_thr (
    .clk(clk), .rst(rst), .thr_en(ier[1]), .thre(thre),
    .tx_empty_evt(tx_empty_evt), .thr_wr(thr_wr), .iir_rd(iir_rd),
    .shown_thre(iir[3:0] == CODE_THRE), .pend(thr_pend)
  );

  always_comb begin
    req           = '0;
    req[SRC_LINE] = ier[2] & (|lsr_sticky | pe_flag | fe_flag);
    req[SRC_TOUT] = ier[0] & tout_pend;
    req[SRC_RXD]  = ier[0] & data_ready & (~fifo_en | (rx_count >= level));
    req[SRC_THRE] = ier[1] & thr_pend;
    req[SRC_MDM]  = ier[3] & (|msr_delta);
  end

  uart_irq_prio u_prio (
    .clk(clk), .rst(rst), .req(req), .fifo_en(fifo_en),
    .iir(iir), .irq(irq)
  );
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] ier,
  input logic       fifo_en,
  input logic       pe_flag,
  input logic       fe_flag,
  input logic       oe_evt,
  input logic       brk_evt,
  input logic       lsr_rd,
  input logic       msr_rd,
  input logic [3:0] modem_lines,
  input logic [7:0] iir,
  input logic       irq,
  input logic [1:0] lsr_sticky,
  input logic [3:0] msr_delta
);
  AST_IRQ_MATCHES_CODE: assert property (@(posedge clk) disable iff (rst)
    irq == (iir[3:0] != 4'h1)); // R7
  AST_FIFO_BITS_ON: assert property (@(posedge clk) disable iff (rst)
    fifo_en |=> iir[7:4] == 4'hC); // R6
  AST_FIFO_BITS_OFF: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> iir[7:4] == 4'h0); // R6
  AST_LINE_WINS: assert property (@(posedge clk) disable iff (rst)
    (ier[2] && (pe_flag || fe_flag)) |=> iir[3:0] == 4'h6); // R3
  AST_TOUT_GATED: assert property (@(posedge clk) disable iff (rst)
    !ier[0] |=> iir[3:0] != 4'hC); // R4
  AST_LSR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !oe_evt && !brk_evt) |=> lsr_sticky == 2'b00); // R9
  AST_MSR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (msr_rd && $stable(modem_lines)) |=> msr_delta == 4'h0); // R10
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (.*);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic [3:0] ier;
  logic fifo_en;
  logic [1:0] trig_sel;
  logic [CW-1:0] rx_count;
  logic data_ready, tout_pend, pe_flag, fe_flag, oe_evt, brk_evt;
  logic thre, tx_empty_evt, thr_wr;
  logic [3:0] modem_lines;
  logic iir_rd, lsr_rd, msr_rd;
  logic [7:0] iir;
  logic irq;
  logic [1:0] lsr_sticky;
  logic [3:0] msr_delta;

  uart_irq_ident #(.DEPTH(DEPTH)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic m_oe, m_bi, m_thrp, m_pier1;
  logic [3:0] m_delta, m_prev;
  logic [7:0] m_iir;

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int lvl(logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return DEPTH / 4;
      2'd2: return DEPTH / 2;
      default: return DEPTH - 2;
    endcase
  endfunction

  function automatic logic [3:0] mcode();
    if (ier[2] && (m_oe || m_bi || pe_flag || fe_flag)) return 4'h6;
    if (ier[0] && tout_pend) return 4'hC;
    if (ier[0] && data_ready && (!fifo_en || int'(rx_count) >= lvl(trig_sel))) return 4'h4;
    if (ier[1] && m_thrp) return 4'h2;
    if (ier[3] && (m_delta != 0)) return 4'h0;
    return 4'h1;
  endfunction

  task automatic cyc(string tag);
    logic [3:0] c, chg;
    logic set, clr;
    c = mcode();
    chg = {modem_lines[3] ^ m_prev[3], m_prev[2] & ~modem_lines[2],
           modem_lines[1] ^ m_prev[1], modem_lines[0] ^ m_prev[0]};
    m_delta = chg | (m_delta & {4{~msr_rd}});
    m_prev = modem_lines;
    m_oe = oe_evt | (m_oe & ~lsr_rd);
    m_bi = brk_evt | (m_bi & ~lsr_rd);
    set = tx_empty_evt | (ier[1] & ~m_pier1 & thre);
    clr = thr_wr | (iir_rd && m_iir[3:0] == 4'h2);
    m_thrp = set | (m_thrp & ~clr);
    m_pier1 = ier[1];
    m_iir = {{2{fifo_en}}, 2'b00, c};
    @(posedge clk);
    @(negedge clk);
    chk(tag, "iir", iir, m_iir);
    chk("R7", "irq", {7'd0, irq}, {7'd0, m_iir[3:0] != 4'h1});
    chk("R9", "lsr_sticky", {6'd0, lsr_sticky}, {6'd0, m_bi, m_oe});
    chk("R10", "msr_delta", {4'd0, msr_delta}, {4'd0, m_delta});
    oe_evt = 0; brk_evt = 0; tx_empty_evt = 0; thr_wr = 0;
    iir_rd = 0; lsr_rd = 0; msr_rd = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst = 1; ier = 0; fifo_en = 0; trig_sel = 0; rx_count = 0;
    data_ready = 0; tout_pend = 0; pe_flag = 0; fe_flag = 0;
    oe_evt = 1; brk_evt = 1; thre = 0; tx_empty_evt = 1; thr_wr = 0;
    modem_lines = 4'b1011; iir_rd = 0; lsr_rd = 0; msr_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    oe_evt = 0; brk_evt = 0; tx_empty_evt = 0;
    chk("R1", "iir", iir, 8'h01);
    chk("R1", "irq", {7'd0, irq}, 8'h00);
    chk("R1", "lsr_sticky", {6'd0, lsr_sticky}, 8'h00);
    chk("R1", "msr_delta", {4'd0, msr_delta}, 8'h00);
    rst = 0;
    m_oe = 0; m_bi = 0; m_thrp = 0; m_pier1 = 0; m_delta = 0;
    m_prev = modem_lines; m_iir = 8'h01;

    // R5: trigger level thresholds, FIFO on
    ier = 4'h1; fifo_en = 1; data_ready = 1;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      rx_count = CW'(lvl(2'(s)) - 1);
      cyc("R5");
      chk("R5", "below level", iir, 8'hC1);
      rx_count = CW'(lvl(2'(s)));
      cyc("R5");
      chk("R5", "at level", iir, 8'hC4);
    end
    // R5: FIFO off, count ignored
    fifo_en = 0; rx_count = 0;
    cyc("R5");
    chk("R5", "fifo off", iir, 8'h04);
    // R4 / R6: timeout gated by ier[0] only
    data_ready = 0; tout_pend = 1; ier = 4'hE; fifo_en = 1;
    cyc("R4");
    chk("R4", "timeout masked", iir, 8'hC1);
    ier = 4'h1;
    cyc("R4");
    chk("R4", "timeout shown", iir, 8'hCC);
    // R2 priority walk, R8 read of THRE code, R11 set by event
    fifo_en = 0; ier = 4'hF; pe_flag = 1; data_ready = 1; thre = 1;
    tx_empty_evt = 1; modem_lines[0] = ~modem_lines[0];
    cyc("R3");
    chk("R3", "line status", iir, 8'h06);
    pe_flag = 0;
    cyc("R2");
    chk("R2", "timeout next", iir, 8'h0C);
    tout_pend = 0;
    cyc("R2");
    chk("R2", "rx data next", iir, 8'h04);
    iir_rd = 1;
    data_ready = 0;
    cyc("R8");
    chk("R8", "thre after non-thre read", iir, 8'h02);
    iir_rd = 1;
    cyc("R8");
    chk("R8", "read cycle", iir, 8'h02);
    cyc("R8");
    chk("R8", "thre cleared", iir, 8'h00);
    msr_rd = 1;
    cyc("R10");
    cyc("R10");
    chk("R10", "modem cleared", iir, 8'h01);
    // R10: RI rising does not set, falling does
    modem_lines[2] = 1;
    cyc("R10");
    chk("R10", "ri rise", {4'd0, msr_delta}, 8'h00);
    modem_lines[2] = 0;
    cyc("R10");
    chk("R10", "ri fall", {4'd0, msr_delta}, 8'h04);
    msr_rd = 1;
    cyc("R10");
    // R9: set wins over read clear
    oe_evt = 1; lsr_rd = 1;
    cyc("R9");
    chk("R9", "set wins", {6'd0, lsr_sticky}, 8'h01);
    lsr_rd = 1;
    cyc("R9");
    chk("R9", "read clears", {6'd0, lsr_sticky}, 8'h00);
    // R11: enable rising while THRE high, then write clears
    ier = 4'h0; thre = 1;
    cyc("R11");
    ier = 4'h2;
    cyc("R11");
    cyc("R11");
    chk("R11", "enable raises", iir, 8'h02);
    thr_wr = 1;
    cyc("R11");
    cyc("R11");
    chk("R11", "write clears", iir, 8'h01);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      ier = 4'($urandom);
      fifo_en = ($urandom % 4) != 0;
      trig_sel = 2'($urandom);
      rx_count = CW'($urandom % (DEPTH + 1));
      data_ready = ($urandom % 2) != 0;
      tout_pend = ($urandom % 5) == 0;
      pe_flag = ($urandom % 9) == 0;
      fe_flag = ($urandom % 9) == 0;
      oe_evt = ($urandom % 11) == 0;
      brk_evt = ($urandom % 13) == 0;
      thre = ($urandom % 2) != 0;
      tx_empty_evt = ($urandom % 7) == 0;
      thr_wr = ($urandom % 7) == 0;
      if (($urandom % 6) == 0) modem_lines = 4'($urandom);
      iir_rd = ($urandom % 3) == 0;
      lsr_rd = ($urandom % 4) == 0;
      msr_rd = ($urandom % 4) == 0;
      cyc("R2");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule